// File: doc/BRIEF.md
# I2C Master Transmit Engine

This block is the transmit half of a two-wire serial bus master. Control inputs select the operation. A start request places a start condition on an idle bus. A data write then clocks out a frame of 1 to 8 bits, in either bit order, and the block samples the receiver's acknowledge on a ninth clock. A stop request releases the bus with a stop condition. The first frame after a start is by convention the 7-bit target address followed by a direction bit (1 = target sends to master, 0 = master sends to target). The block treats that frame as ordinary frame data.

Both bus wires are open-drain. The block pulls a wire low by asserting its output-enable and reads the resolved line levels back on separate inputs. A programmable divider sets the length of each half bit period. A bus monitor watches the resolved lines for start and stop conditions from any master and keeps a bus-busy flag. A second format, the plain serial format, sends raw frames with no start condition, no address convention and no acknowledge clock, and closes with a stop.

Top module: `i2c_tx_master`

## Requirements
- R1: After reset, scl_oe, sda_oe, busy, tx_done and ack_nak are all 0.
- R2: A start request (busy_wr=1, busy_wdata=1, en=1, master_tx=1) in idle with busy=0 and fmt_sel other than 2'b11 asserts sda_oe while scl_oe stays 0 for clk_div+1 cycles. The block then asserts scl_oe and keeps sda_oe asserted until the next command.
- R3: A start request is ignored (lines stay released) when busy=1 or when fmt_sel=2'b11.
- R4: Each data bit holds scl_oe=1 for clk_div+1 cycles with sda_oe equal to the inverted bit, then scl_oe=0 for clk_div+1 cycles with sda_oe unchanged. Outside start and stop generation, sda_oe changes only while scl_oe=1 or in the cycle scl_oe rises.
- R5: A bit_cnt value of 0 gives an 8-bit frame. Any other value k gives a k-bit frame taken from data_in[k-1:0].
- R6: With lsb_first=0 the frame is sent from data_in[k-1] down to data_in[0]. With lsb_first=1 it is sent from data_in[0] up to data_in[k-1].
- R7: In the addressed format each frame is followed by a ninth clock (scl_oe=1 then 0, each for clk_div+1 cycles) with sda_oe=0. The SDA level at the end of its high half is latched into ack_nak (0 = acknowledged). tx_done is high for exactly one cycle, in the first cycle after the frame.
- R8: With fmt_sel=2'b11 a data write from idle or from hold sends the frame with no start condition and no ninth clock, and tx_done still pulses. Busy stays 0.
- R9: A stop request (busy_wr=1, busy_wdata=0) in hold gives scl_oe=1, sda_oe=1 for clk_div+1 cycles, then scl_oe=0, sda_oe=1 for clk_div+1 cycles, then releases both lines.
- R10: busy sets after SDA falls while SCL is high on the resolved lines and clears after SDA rises while SCL is high, whichever master caused it.
- R11: A data write in idle in the addressed format is ignored.
- R12: A data write and a stop request in the same hold cycle: the frame is sent and the stop request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Engine enable |
| master_tx | input | 1 | Master transmit mode select |
| busy_wr | input | 1 | Strobe: write of the bus-busy control bit |
| busy_wdata | input | 1 | Value written with busy_wr: 1 requests start, 0 requests stop |
| fmt_sel | input | 2 | Format select; 2'b11 selects plain serial format |
| bit_cnt | input | 3 | Frame length, 0 means 8 |
| lsb_first | input | 1 | Bit order: 1 sends LSB first |
| data_wr | input | 1 | Strobe: frame data write |
| data_in | input | 8 | Frame data |
| clk_div | input | DIV_W | Half bit period minus one, in clock cycles |
| scl_in | input | 1 | Resolved SCL line level |
| sda_in | input | 1 | Resolved SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | Bus-busy flag |
| ack_nak | output | 1 | Last sampled acknowledge level, 1 = not acknowledged |
| tx_done | output | 1 | One-cycle frame-complete pulse |

## Verification
Two things can land in the same hold cycle: a data write and a stop request. The bench raises data_wr and a busy_wr of 0 on the same edge. Its per-cycle reference queue holds only the frame and its ninth clock, followed by an indefinite hold. Any stop phase that appears in that time is a mismatch against the queue. A second overlap is internal. The acknowledge sample, the tx_done pulse and the return to hold all take effect on one edge. The bench judges this by the tx_done flag carried in its queue entry and by reading ack_nak once the queue has drained.

// File: rtl/i2c_tx_pkg.sv
package i2c_tx_pkg;
  localparam int FRAME_W = 8;
  localparam int BC_W    = $clog2(FRAME_W);
  localparam int LEN_W   = BC_W + 1;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_HOLD, ST_BLO, ST_BHI, ST_ALO, ST_AHI, ST_PLO, ST_PHI
  } phase_e;

  // frame length: zero code stands for the full width
  function automatic logic [LEN_W-1:0] frame_len(input logic [BC_W-1:0] bc);
    return (bc == '0) ? LEN_W'(FRAME_W) : {1'b0, bc};
  endfunction

  // bit sent at step idx of an n-bit frame
  function automatic logic pick_bit(input logic [FRAME_W-1:0] d,
                                    input logic [LEN_W-1:0] n,
                                    input logic [BC_W-1:0] idx,
                                    input logic lsb);
    logic [LEN_W-1:0] pos;
    pos = lsb ? LEN_W'(idx) : (n - LEN_W'(1) - LEN_W'(idx));
    return d[pos[BC_W-1:0]];
  endfunction
endpackage

// File: rtl/i2c_tx_phase_timer.sv
module i2c_tx_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $stable(div)) |-> (cnt_q <= div));
endmodule

// File: rtl/i2c_tx_bus_monitor.sv
module i2c_tx_bus_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic busy,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  assign start_det = scl_q && scl_in && sda_q && !sda_in;
  assign stop_det  = scl_q && scl_in && !sda_q && sda_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      if (start_det)     busy <= 1'b1;
      else if (stop_det) busy <= 1'b0;
    end
  end

  p_stop_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !busy);
endmodule

// File: rtl/i2c_tx_shifter.sv
module i2c_tx_shifter
  import i2c_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               adv,
  input  logic [FRAME_W-1:0] d_in,
  input  logic [BC_W-1:0]    bc_in,
  input  logic               lsb_in,
  output logic               bit_o,
  output logic               last_o
);
  logic [FRAME_W-1:0] d_q;
  logic [LEN_W-1:0]   n_q;
  logic [BC_W-1:0]    idx_q;
  logic               lsb_q;

  assign bit_o  = pick_bit(d_q, n_q, idx_q, lsb_q);
  assign last_o = (LEN_W'(idx_q) == (n_q - LEN_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q   <= '0;
      n_q   <= LEN_W'(1);
      idx_q <= '0;
      lsb_q <= 1'b0;
    end else if (load) begin
      d_q   <= d_in;
      n_q   <= frame_len(bc_in);
      idx_q <= '0;
      lsb_q <= lsb_in;
    end else if (adv) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    LEN_W'(idx_q) < n_q);
endmodule

// File: rtl/i2c_tx_master.sv
module i2c_tx_master
  import i2c_tx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               master_tx,
  input  logic               busy_wr,
  input  logic               busy_wdata,
  input  logic [1:0]         fmt_sel,
  input  logic [BC_W-1:0]    bit_cnt,
  input  logic               lsb_first,
  input  logic               data_wr,
  input  logic [FRAME_W-1:0] data_in,
  input  logic [DIV_W-1:0]   clk_div,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               scl_oe,
  output logic               sda_oe,
  output logic               busy,
  output logic               ack_nak,
  output logic               tx_done
);
  phase_e st_q, st_d;
  logic tick, run, cur_bit, last_bit;
  logic sda_last_q, serial_q;
  logic start_det, stop_det;

  // named events
  wire is_serial  = (fmt_sel == 2'b11);
  wire ctl_ok     = en && master_tx;
  wire start_req  = ctl_ok && busy_wr && busy_wdata && !busy && !is_serial;
  wire stop_req   = ctl_ok && busy_wr && !busy_wdata;
  wire frame_req  = ctl_ok && data_wr;
  wire load       = frame_req && ((st_q == ST_HOLD) || (st_q == ST_IDLE && is_serial));
  wire bit_end    = tick && (st_q == ST_BHI);
  wire adv        = bit_end && !last_bit;
  wire ack_sample = tick && (st_q == ST_AHI);
  wire frame_end  = ack_sample || (bit_end && last_bit && serial_q);

  assign run = !(st_q == ST_IDLE || st_q == ST_HOLD);

  i2c_tx_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .div(clk_div), .tick(tick));

  i2c_tx_bus_monitor u_mon (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .busy(busy), .start_det(start_det), .stop_det(stop_det));

  i2c_tx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(adv), .d_in(data_in),
    .bc_in(bit_cnt), .lsb_in(lsb_first), .bit_o(cur_bit), .last_o(last_bit));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_req) st_d = ST_START;
                else if (load) st_d = ST_BLO;
      ST_START: if (tick) st_d = ST_HOLD;
      ST_HOLD:  if (load) st_d = ST_BLO;        // data wins over stop
                else if (stop_req) st_d = ST_PLO;
      ST_BLO:   if (tick) st_d = ST_BHI;
      ST_BHI:   if (tick) st_d = !last_bit ? ST_BLO : (serial_q ? ST_HOLD : ST_ALO);
      ST_ALO:   if (tick) st_d = ST_AHI;
      ST_AHI:   if (tick) st_d = ST_HOLD;
      ST_PLO:   if (tick) st_d = ST_PHI;
      ST_PHI:   if (tick) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_q)
      ST_START: begin scl_oe = 1'b0; sda_oe = 1'b1;       end
      ST_HOLD:  begin scl_oe = 1'b1; sda_oe = sda_last_q; end
      ST_BLO:   begin scl_oe = 1'b1; sda_oe = !cur_bit;   end
      ST_BHI:   begin scl_oe = 1'b0; sda_oe = !cur_bit;   end
      ST_ALO:   begin scl_oe = 1'b1; sda_oe = 1'b0;       end
      ST_AHI:   begin scl_oe = 1'b0; sda_oe = 1'b0;       end
      ST_PLO:   begin scl_oe = 1'b1; sda_oe = 1'b1;       end
      ST_PHI:   begin scl_oe = 1'b0; sda_oe = 1'b1;       end
      default:  begin scl_oe = 1'b0; sda_oe = 1'b0;       end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      sda_last_q <= 1'b0;
      serial_q   <= 1'b0;
      ack_nak    <= 1'b0;
      tx_done    <= 1'b0;
    end else begin
      st_q       <= st_d;
      sda_last_q <= sda_oe;
      tx_done    <= frame_end;
      if (load)       serial_q <= is_serial;
      if (ack_sample) ack_nak  <= sda_in;
    end
  end

  // SDA moves only with SCL held low, start/stop phases aside
  p_sda_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && !(st_q == ST_START || st_q == ST_IDLE))
      |-> (sda_oe == $past(sda_oe)));
  p_start_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_START && $past(st_q) == ST_IDLE) |-> !$past(busy));
  p_busy_after_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD && $past(st_q) == ST_START) |-> busy);
  p_ack_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ack_nak) |-> ($past(st_q) == ST_AHI));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);
  p_serial_no_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    serial_q |-> (st_q != ST_ALO && st_q != ST_AHI));
endmodule

// File: tb/tb_i2c_tx_master.sv
module tb_i2c_tx_master;
  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic rst_n, en, master_tx, busy_wr, busy_wdata, lsb_first, data_wr;
  logic [1:0] fmt_sel;
  logic [2:0] bit_cnt;
  logic [7:0] data_in, clk_div;
  logic scl_oe, sda_oe, busy, ack_nak, tx_done;
  logic slave_pull, ext_pull;
  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || slave_pull || ext_pull);

  i2c_tx_master dut (
    .clk(clk), .rst_n(rst_n), .en(en), .master_tx(master_tx),
    .busy_wr(busy_wr), .busy_wdata(busy_wdata), .fmt_sel(fmt_sel),
    .bit_cnt(bit_cnt), .lsb_first(lsb_first), .data_wr(data_wr),
    .data_in(data_in), .clk_div(clk_div), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .ack_nak(ack_nak), .tx_done(tx_done));

  // reference: one entry per cycle {done, slave pull, scl_oe, sda_oe}
  logic [3:0] exp_q[$];
  logic rest_scl = 1'b0, rest_sda = 1'b0;
  int hp = 4;
  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  task automatic chk(input logic ok, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    logic [3:0] e;
    #5;
    if (rst_n) begin
      e = (exp_q.size() != 0) ? exp_q.pop_front() : {2'b00, rest_scl, rest_sda};
      slave_pull = e[2];
      chk({scl_oe, sda_oe, tx_done} == {e[1], e[0], e[3]},
          {cur_req, " lines scl_oe,sda_oe,tx_done"},
          int'({scl_oe, sda_oe, tx_done}), int'({e[1], e[0], e[3]}));
    end
  end

  task automatic push_ph(input logic s, input logic d, input logic p);
    for (int k = 0; k < hp; k++) exp_q.push_back({1'b0, p, s, d});
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic do_start(input logic expect_go, input string req);
    @(negedge clk);
    cur_req = req; busy_wr = 1'b1; busy_wdata = 1'b1;
    if (expect_go) begin
      push_ph(1'b0, 1'b1, 1'b0);
      rest_scl = 1'b1; rest_sda = 1'b1;
    end
    @(negedge clk);
    busy_wr = 1'b0;
    drain();
    repeat (2) @(negedge clk);
  endtask

  task automatic do_stop(input string req);
    @(negedge clk);
    cur_req = req; busy_wr = 1'b1; busy_wdata = 1'b0;
    push_ph(1'b1, 1'b1, 1'b0);
    push_ph(1'b0, 1'b1, 1'b0);
    rest_scl = 1'b0; rest_sda = 1'b0;
    @(negedge clk);
    busy_wr = 1'b0;
    drain();
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, {req, " busy after stop"}, int'(busy), 0);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [2:0] bc, input logic lsb,
                            input logic serial, input logic ack, input logic with_stop,
                            input string req);
    int n;
    logic b, last;
    n = (bc == 3'd0) ? 8 : int'(bc);
    b = 1'b0;
    @(negedge clk);
    cur_req = req; data_in = d; bit_cnt = bc; lsb_first = lsb; data_wr = 1'b1;
    if (with_stop) begin busy_wr = 1'b1; busy_wdata = 1'b0; end
    for (int i = 0; i < n; i++) begin
      b = lsb ? d[i] : d[n-1-i];
      push_ph(1'b1, !b, 1'b0);
      push_ph(1'b0, !b, 1'b0);
    end
    if (!serial) begin
      push_ph(1'b1, 1'b0, ack);
      push_ph(1'b0, 1'b0, ack);
      last = 1'b0;
    end else begin
      last = !b;
    end
    exp_q.push_back({1'b1, 1'b0, 1'b1, last});
    rest_scl = 1'b1; rest_sda = last;
    @(negedge clk);
    data_wr = 1'b0; busy_wr = 1'b0;
    drain();
    if (!serial) chk(ack_nak == !ack, {req, " R7 ack_nak"}, int'(ack_nak), int'(!ack));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; master_tx = 1'b1; busy_wr = 1'b0; busy_wdata = 1'b0;
    fmt_sel = 2'b00; bit_cnt = 3'd0; lsb_first = 1'b0; data_wr = 1'b0; data_in = 8'h00;
    clk_div = 8'd3; hp = 4; slave_pull = 1'b0; ext_pull = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values
    chk({scl_oe, sda_oe, busy, tx_done, ack_nak} == 5'b0, "R1 reset outputs",
        int'({scl_oe, sda_oe, busy, tx_done, ack_nak}), 0);
    repeat (3) @(negedge clk);

    // R2 start, then address frame and two data frames (R4 R5 R6 R7)
    do_start(1'b1, "R2");
    chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
    send_frame(8'hB4, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R5 R6 R4 addr msb 8-bit");
    send_frame(8'h3C, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0, "R5 R6 lsb 5-bit nak");
    send_frame(8'h01, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0, "R5 1-bit");
    repeat (6) @(negedge clk);
    do_stop("R9");

    // R11: data write in idle, addressed format
    @(negedge clk);
    cur_req = "R11"; data_in = 8'hFF; data_wr = 1'b1;
    @(negedge clk);
    data_wr = 1'b0;
    repeat (12) @(negedge clk);

    // R10 / R3: another master holds the bus
    ext_pull = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R10 external start", int'(busy), 1);
    do_start(1'b0, "R3 busy");
    repeat (8) @(negedge clk);
    ext_pull = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10 external stop", int'(busy), 0);

    // minimum divider, R12 overlap of data write and stop
    clk_div = 8'd0; hp = 1;
    do_start(1'b1, "R2 div0");
    send_frame(8'hA5, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, "R6 R4 lsb div0");
    send_frame(8'h0F, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1, "R12 frame with stop");
    repeat (10) @(negedge clk);
    chk(busy == 1'b1, "R12 bus still held", int'(busy), 1);
    do_stop("R9 div0");

    // R8 plain serial format
    clk_div = 8'd2; hp = 3; fmt_sel = 2'b11;
    do_start(1'b0, "R3 serial");
    send_frame(8'hC3, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R8 serial from idle");
    chk(busy == 1'b0, "R8 no start in serial", int'(busy), 0);
    send_frame(8'h06, 3'd4, 1'b1, 1'b1, 1'b0, 1'b0, "R8 serial lsb 4-bit");
    do_stop("R8 R9 serial");
    repeat (5) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule